// File: doc/BRIEF.md
# I2C Serial Clock Divider

This block derives the I2C serial clock from the peripheral clock. Software writes a 12-bit divide value through two byte-wide configuration registers. The main control byte carries the low seven divide bits and a mode bit that selects fast or standard timing. The extension byte carries the upper five bits. The block drives SCL as an open-drain pull: it pulls the line low for the low phase, then releases it for the high phase.

The high phase is counted only while the SCL line, seen through a synchronizer, reads high. A target that holds the clock low therefore lengthens the period by exactly the time it holds the line. At every high-to-low turn the block gives the byte engine a one-cycle tick.

A new divide value or mode takes effect only at the start of the next period. Clearing the peripheral enable stops the divider and releases the line.

Top module: `i2c_scl_divider`

## Requirements
- R1: While reset is asserted, and until the first enable after it, `scl_pull_low` and `bit_tick` are 0.
- R2: A write with `cfg_sel`=0 loads divide bits 6:0 from `cfg_wdata[6:0]`. A write with `cfg_sel`=1 loads divide bits 11:7 from `cfg_wdata[4:0]`, and `cfg_wdata[7:5]` of that write has no effect on timing.
- R3: Bit 7 of the main control byte (`cfg_sel`=0) selects fast timing when 1 and standard timing when 0.
- R4: In standard timing with divide value N, the low phase lasts N+2 clock cycles and the whole SCL period lasts 2N+5 cycles when no target stretches the clock.
- R5: In fast timing with divide value N, the low phase lasts 2N+4 cycles and the period lasts 3N+6 cycles when no target stretches the clock.
- R6: A programmed divide value of 0 or 1 is treated as 2.
- R7: After release, the high phase advances only on cycles where the synchronized `scl_in` is high. Every extra cycle that `scl_in` is held low after release adds one cycle to the period.
- R8: A configuration write during a period leaves that period's timing unchanged. The new value governs the next period.
- R9: One cycle after `periph_en` is sampled low, `scl_pull_low` is 0, and it stays 0 while enable is low. One cycle after `periph_en` is sampled high from idle, a low phase begins.
- R10: `bit_tick` is a one-cycle pulse in the first cycle of each low phase that follows a high phase. It does not pulse when a low phase begins from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; low stops the divider |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = main control byte, 1 = extension byte |
| cfg_wdata | input | 8 | Configuration write data |
| scl_in | input | 1 | Sensed SCL line level |
| scl_pull_low | output | 1 | 1 = pull SCL low (open-drain drive) |
| bit_tick | output | 1 | One-cycle pulse at each high-to-low turn |

## Verification
The bench builds the block with its default parameters: a 12-bit divider split 7+5 and two synchronizer stages. With these values the all-ones divide value of 4095 is reachable in fast timing, which fills both fields and the widest counter. The two-stage synchronizer latency is folded into the high-phase count, so exact cycle periods can be compared against the formulas. A bench-side target model stretches the clock by a set number of cycles, and every stretched cycle must appear one for one in the period.

// File: rtl/i2c_scl_div_pkg.sv
`timescale 1ns/1ps
package i2c_scl_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  typedef enum logic {
    SEL_MAIN = 1'b0,
    SEL_EXT  = 1'b1
  } cfg_sel_e;

endpackage

// File: rtl/scl_rst_sync.sv
`timescale 1ns/1ps
module scl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_o
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) shift_q <= '0;
    else          shift_q <= shift_d;
  end

  assign rst_n_o = shift_q[STAGES-1];
endmodule

// File: rtl/scl_line_sync.sv
`timescale 1ns/1ps
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES:0] chain;

  assign chain[0] = line_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= 1'b1;
      else        chain[g+1] <= chain[g];
    end
  end

  assign line_o = chain[STAGES];
endmodule

// File: rtl/scl_cfg_regs.sv
`timescale 1ns/1ps
module scl_cfg_regs
  import i2c_scl_div_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int LO_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [7:0]       wdata_i,
  output logic [DIV_W-1:0] div_o,
  output logic             fast_o
);
  localparam int HI_W = DIV_W - LO_W;

  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            fast_q, fast_d;
  logic            lo_en, hi_en;

  always_comb begin
    lo_en  = wr_i && (cfg_sel_e'(sel_i) == SEL_MAIN);
    hi_en  = wr_i && (cfg_sel_e'(sel_i) == SEL_EXT);
    lo_d   = wdata_i[LO_W-1:0];
    fast_d = wdata_i[7];
    hi_d   = wdata_i[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      fast_q <= 1'b0;
    end else if (lo_en) begin
      lo_q   <= lo_d;
      fast_q <= fast_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_en) hi_q <= hi_d;
  end

  assign div_o  = {hi_q, lo_q};
  assign fast_o = fast_q;

  // R2: an extension write never disturbs the low field or the mode bit
  p_ext_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_en |=> ($stable(lo_q) && $stable(fast_q)));
endmodule

// File: rtl/scl_phase_gen.sv
`timescale 1ns/1ps
module scl_phase_gen
  import i2c_scl_div_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             cfg_fast_i,
  input  logic             line_hi_i,
  output logic             pull_low_o,
  output logic             tick_o
);
  localparam int CNT_W = DIV_W + 2;
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  scl_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d, div_clamp;
  logic             fast_q, fast_d;
  logic             tick_q, tick_d;
  logic             load;
  logic [CNT_W-1:0] n_ext, low_len, high_len, high_wait;

  // phase lengths from the active divide value
  always_comb begin
    n_ext     = CNT_W'(div_q);
    low_len   = fast_q ? ((n_ext << 1) + CNT_W'(4)) : (n_ext + CNT_W'(2));
    high_len  = fast_q ? (n_ext + CNT_W'(2))        : (n_ext + CNT_W'(3));
    high_wait = high_len - CNT_W'(SYNC_STAGES);
    div_clamp = (cfg_div_i < DIV_MIN) ? DIV_MIN : cfg_div_i;
  end

  // next state
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    tick_d  = 1'b0;
    load    = 1'b0;
    if (!en_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          phase_d = PH_LOW;
          cnt_d   = '0;
          load    = 1'b1;
        end
        PH_LOW: begin
          if (cnt_q == low_len - CNT_W'(1)) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (line_hi_i) begin
            if (cnt_q == high_wait - CNT_W'(1)) begin
              phase_d = PH_LOW;
              cnt_d   = '0;
              load    = 1'b1;
              tick_d  = 1'b1;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
    div_d  = load ? div_clamp  : div_q;
    fast_d = load ? cfg_fast_i : fast_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      div_q   <= DIV_MIN;
      fast_q  <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      div_q   <= div_d;
      fast_q  <= fast_d;
      tick_q  <= tick_d;
    end
  end

  assign pull_low_o = (phase_q == PH_LOW);
  assign tick_o     = tick_q;

  // R9: a cleared enable releases the line on the next cycle
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pull_low_o);

  // R10: the byte-engine tick lands in a low cycle
  p_tick_in_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> pull_low_o);

  // R6: the active divide value never falls below two
  p_div_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> (div_q >= DIV_MIN));

  // R8: once a low phase is under way, the active value is frozen
  p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW && cnt_q != '0) |-> ($stable(div_q) && $stable(fast_q)));

  // R7: a line held low stalls the high-phase count
  p_stretch_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH && !line_hi_i && en_i) |=> (phase_q == PH_HIGH && $stable(cnt_q)));

  // R4: the low counter stays within the phase length
  p_low_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (cnt_q < low_len));
endmodule

// File: rtl/i2c_scl_divider.sv
`timescale 1ns/1ps
module i2c_scl_divider #(
  parameter int DIV_W       = 12,
  parameter int LO_W        = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       periph_en,
  input  logic       cfg_wr,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  input  logic       scl_in,
  output logic       scl_pull_low,
  output logic       bit_tick
);
  logic             rst_n_s;
  logic [DIV_W-1:0] cfg_div;
  logic             cfg_fast;
  logic             line_hi;

  scl_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_o (rst_n_s)
  );

  scl_cfg_regs #(.DIV_W(DIV_W), .LO_W(LO_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_i    (cfg_wr),
    .sel_i   (cfg_sel),
    .wdata_i (cfg_wdata),
    .div_o   (cfg_div),
    .fast_o  (cfg_fast)
  );

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .line_i (scl_in),
    .line_o (line_hi)
  );

  scl_phase_gen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en_i       (periph_en),
    .cfg_div_i  (cfg_div),
    .cfg_fast_i (cfg_fast),
    .line_hi_i  (line_hi),
    .pull_low_o (scl_pull_low),
    .tick_o     (bit_tick)
  );
endmodule

// File: tb/i2c_scl_divider_test.sv
`timescale 1ns/1ps
module i2c_scl_divider_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       periph_en;
  logic       cfg_wr;
  logic       cfg_sel;
  logic [7:0] cfg_wdata;
  logic       scl_line;
  logic       scl_pull_low;
  logic       bit_tick;

  int n_chk  = 0;
  int n_fail = 0;
  int stretch_k = 0;
  int hold_cnt  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_scl_divider uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .periph_en    (periph_en),
    .cfg_wr       (cfg_wr),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .scl_in       (scl_line),
    .scl_pull_low (scl_pull_low),
    .bit_tick     (bit_tick)
  );

  // target model: holds SCL low for stretch_k cycles after each release
  always @(posedge clk) begin
    if (scl_pull_low)      hold_cnt <= stretch_k;
    else if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
  end
  assign scl_line = !scl_pull_low && (hold_cnt == 0);

  // vectors: main byte, extension byte, stretch, expected low, expected period
  localparam int NV = 13;
  localparam logic [7:0] V_MAIN [NV] = '{8'h02, 8'h05, 8'h64, 8'h48, 8'h82, 8'h8A, 8'hAC,
                                         8'h05, 8'h8A, 8'h00, 8'h81, 8'h05, 8'hFF};
  localparam logic [7:0] V_EXT  [NV] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h02,
                                         8'h00, 8'h00, 8'h00, 8'h00, 8'hE1, 8'h1F};
  localparam int V_STR [NV] = '{0, 0, 0, 0, 0, 0, 0, 6, 3, 0, 0, 0, 0};
  localparam int V_LOW [NV] = '{4, 7, 102, 202, 8, 24, 604, 7, 24, 4, 8, 135, 8194};
  localparam int V_PER [NV] = '{9, 15, 205, 405, 12, 36, 906, 21, 39, 9, 12, 271, 12291};

  function automatic string vreq(int i);
    case (i)
      0, 1, 2:  return "R4";
      3, 11:    return "R2";
      4, 5, 6:  return "R5 R3";
      7, 8:     return "R7";
      9, 10:    return "R6";
      default:  return "R5 R2";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] data);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 50 && !scl_pull_low; i++) @(negedge clk);
  endtask

  // starts on the negedge where a low phase was first seen; ends on the next one
  task automatic measure(input int wr_at, input logic [7:0] wr_val,
                         output int lowc, output int per, output int ticks, output int end_tick);
    int k;
    logic p;
    k = 0; lowc = 0; ticks = 0;
    forever begin
      if (scl_pull_low) lowc++;
      if (bit_tick) ticks++;
      cfg_wr = (k == wr_at); cfg_sel = 1'b0; cfg_wdata = wr_val;
      p = scl_pull_low;
      @(negedge clk);
      k++;
      if ((scl_pull_low && !p) || k > 20000) break;
    end
    cfg_wr = 1'b0;
    per = k;
    end_tick = int'(bit_tick);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lowc, per, ticks, et;
    rst_n = 1'b0; periph_en = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state, even with enable raised during reset
    periph_en = 1'b1;
    @(negedge clk);
    chk("R1 pull", int'(scl_pull_low), 0);
    chk("R1 tick", int'(bit_tick), 0);
    periph_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pull after release", int'(scl_pull_low), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      periph_en = 1'b0;
      repeat (3) @(negedge clk);
      wr(1'b0, V_MAIN[i]);
      wr(1'b1, V_EXT[i]);
      stretch_k = V_STR[i];
      periph_en = 1'b1;
      @(negedge clk);
      chk("R9 start low", int'(scl_pull_low), 1);
      measure(-1, 8'h00, lowc, per, ticks, et);
      chk(vreq(i), lowc, V_LOW[i]);
      chk(vreq(i), per, V_PER[i]);
      chk("R10 no tick mid-period", ticks, 0);
      chk("R10 tick at turn", et, 1);
    end
    stretch_k = 0;

    // R8: write during a period only affects the next period
    periph_en = 1'b0;
    repeat (3) @(negedge clk);
    wr(1'b0, 8'h05);
    wr(1'b1, 8'h00);
    periph_en = 1'b1;
    wait_rise();
    measure(2, 8'h14, lowc, per, ticks, et);
    chk("R8 current low", lowc, 7);
    chk("R8 current period", per, 15);
    measure(-1, 8'h00, lowc, per, ticks, et);
    chk("R8 next low", lowc, 22);
    chk("R8 next period", per, 45);

    // R9: disable mid-period
    repeat (3) @(negedge clk);
    periph_en = 1'b0;
    @(negedge clk);
    chk("R9 released", int'(scl_pull_low), 0);
    ticks = 0; lowc = 0;
    for (int i = 0; i < 60; i++) begin
      if (scl_pull_low) lowc++;
      if (bit_tick) ticks++;
      @(negedge clk);
    end
    chk("R9 stays released", lowc, 0);
    chk("R9 no tick while idle", ticks, 0);
    periph_en = 1'b1;
    @(negedge clk);
    chk("R9 restart low", int'(scl_pull_low), 1);
    chk("R10 no tick from idle", int'(bit_tick), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule